// File: doc/BRIEF.md
# Memory-Cell Image Capture Sequencer

This block turns a light-exposed dynamic memory array into a binary image sensor. For each exposure pass it fills every cell with one known value, leaves the array untouched for a set number of cycles while light disturbs the stored charge, and then reads every cell back. A cell whose value no longer matches the fill value is reported as a lit pixel. A capture is a series of passes with exposure lengths that grow from pass to pass. Counting, for each pixel, the passes in which it was lit gives a grayscale value.

The cell address of a pixel need not match its place in the picture. Readout therefore goes through a loadable row table and column table before the pixel coordinates are formed. Grayscale counts are kept in an external frame store that the block reads and writes through a separate port. Every pixel is also sent out on a stream. When automatic exposure is enabled, the share of lit readings over the whole capture moves the base exposure up or down by one step, held within fixed limits.

With the default parameters the sensed region is a single bank of 256 columns by 128 rows, addressed as `row * NCOL + col`. The sensor memory and the frame store both have a read latency of one cycle.

Top module: `memcam_top`

## Requirements
- R1: After a start is accepted, the block writes the sampled fill value to every cell in ascending address order, one cell per cycle, with `mem_we_o` high for exactly NCOL*NROW cycles.
- R2: After the fill of pass k (counted from 0), `mem_we_o` and `mem_re_o` both stay low for exactly `exp_o*(k+1)` cycles before the first read of that pass.
- R3: Each pass reads every cell in ascending address order. A reading that differs from the fill value marks that pixel as lit.
- R4: One capture runs LEVELS = 2^GRAY_W - 1 passes, and each pass does fill, exposure and readout in that order.
- R5: The grayscale value written for a pixel is the number of passes so far in which it was lit, and it saturates at LEVELS. In the first pass the old frame-store contents are ignored and counting starts from zero.
- R6: The pixel column is `col_map[address % NCOL]` and the pixel row is `row_map[address / NCOL]`. The frame-store index is `row * NCOL + col`. Both tables reset to identity. When idle, a table entry is written through `map_we_i`: `map_row_i` = 0 selects the column table and 1 selects the row table.
- R7: Every read issued produces one stream beat with `pix_valid_o` high two cycles later. Each beat carries the mapped column, the mapped row, the lit flag and the updated grayscale value.
- R8: `busy_o` is high from the cycle after an accepted start until the capture ends. `done_o` is high for exactly one cycle, two cycles after the last read is issued. A start while busy is ignored. After reset `busy_o` and `done_o` are low.
- R9: At the end of a capture with `ae_en_i` high, the exposure grows by EXP_STEP when lit readings*4 is less than the total readings, and shrinks by EXP_STEP when lit readings*4 is greater than 3 times the total. The result is clamped to [EXP_MIN, EXP_MAX]. When `ae_en_i` is low the exposure does not change.
- R10: The exposure resets to EXP_MIN. A pulse on `exp_load_i` while idle loads `exp_i` clamped to [EXP_MIN, EXP_MAX].
- R11: `preset_i` is sampled when a start is accepted and gives the fill value (0 or 1) for every pass of that capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a capture (acted on only when idle) |
| preset_i | input | 1 | Fill value for the capture |
| ae_en_i | input | 1 | Enables automatic exposure adjustment |
| exp_load_i | input | 1 | Loads the base exposure |
| exp_i | input | EXP_W | Base exposure value to load |
| map_we_i | input | 1 | Writes a remap table entry |
| map_row_i | input | 1 | Table select: 0 column, 1 row |
| map_idx_i | input | COL_W | Table entry index |
| map_val_i | input | COL_W | Table entry value |
| busy_o | output | 1 | Capture in progress |
| done_o | output | 1 | One-cycle end-of-capture pulse |
| exp_o | output | EXP_W | Current base exposure in cycles |
| mem_addr_o | output | ROW_W+COL_W | Sensor memory address |
| mem_wdata_o | output | 1 | Sensor memory write data |
| mem_we_o | output | 1 | Sensor memory write enable |
| mem_re_o | output | 1 | Sensor memory read enable |
| mem_rdata_i | input | 1 | Sensor memory read data (one cycle latency) |
| gray_raddr_o | output | ROW_W+COL_W | Frame store read index |
| gray_rdata_i | input | GRAY_W | Frame store read data (one cycle latency) |
| gray_waddr_o | output | ROW_W+COL_W | Frame store write index |
| gray_wdata_o | output | GRAY_W | Frame store write data |
| gray_we_o | output | 1 | Frame store write enable |
| pix_valid_o | output | 1 | Stream beat valid |
| pix_x_o | output | COL_W | Mapped pixel column |
| pix_y_o | output | ROW_W | Mapped pixel row |
| pix_lit_o | output | 1 | Pixel lit in this pass |
| pix_gray_o | output | GRAY_W | Updated grayscale count |

## Verification
The hardest case to reach from the ports is a pixel whose grayscale value depends on its history across passes: it must stay dark in the short exposures and turn lit in the longer ones. The frame store must also hold stale contents that a correct first pass has to ignore. The bench models the sensor memory so that each cell flips once the number of quiet cycles in the current pass reaches a threshold set for that cell. The thresholds are spread so that pixels first light in different passes or never light. The frame store model starts filled with the saturation value, and non-identity remap tables scatter the frame-store indices. The auto-exposure decisions are reached by setting all thresholds very low, very high, or split down the middle.

// File: rtl/memcam_pkg.sv
package memcam_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRESET,
    ST_EXPOSE,
    ST_READ,
    ST_FLUSH,
    ST_DONE
  } cap_state_e;
endpackage

// File: rtl/memcam_remap.sv
module memcam_remap #(
  parameter int COL_W = 8,
  parameter int ROW_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             row_sel_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] val_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [COL_W-1:0] x_o,
  output logic [ROW_W-1:0] y_o
);
  localparam int NCOL = 1 << COL_W;
  localparam int NROW = 1 << ROW_W;

  logic [COL_W-1:0] cmap_q [NCOL];
  logic [ROW_W-1:0] rmap_q [NROW];

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cmap_q[c] <= COL_W'(c);
      else if (we_i && !row_sel_i && idx_i == COL_W'(c)) cmap_q[c] <= val_i;
    end
  end

  for (genvar r = 0; r < NROW; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rmap_q[r] <= ROW_W'(r);
      else if (we_i && row_sel_i && idx_i[ROW_W-1:0] == ROW_W'(r))
        rmap_q[r] <= val_i[ROW_W-1:0];
    end
  end

  assign x_o = cmap_q[col_i];
  assign y_o = rmap_q[row_i];
endmodule

// File: rtl/memcam_expo.sv
module memcam_expo #(
  parameter int EXP_W    = 16,
  parameter int EXP_MIN  = 1,
  parameter int EXP_MAX  = 60000,
  parameter int EXP_STEP = 16,
  parameter int CNT_W    = 17,
  parameter int TOTAL    = 98304
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [EXP_W-1:0] val_i,
  input  logic             adj_i,
  input  logic             ae_en_i,
  input  logic [CNT_W-1:0] lit_cnt_i,
  output logic [EXP_W-1:0] exp_o
);
  localparam logic [EXP_W-1:0] MIN_V  = EXP_W'(EXP_MIN);
  localparam logic [EXP_W-1:0] MAX_V  = EXP_W'(EXP_MAX);
  localparam logic [EXP_W:0]   STEP_V = (EXP_W+1)'(EXP_STEP);
  localparam int CW = CNT_W + 3;
  localparam logic [CW-1:0] TOT1 = CW'(TOTAL);
  localparam logic [CW-1:0] TOT3 = CW'(3 * TOTAL);

  logic [EXP_W-1:0] exp_q, clamp_v, nxt_v;
  logic [EXP_W:0]   up_sum;
  logic [CW-1:0]    lit4;

  always_comb begin
    clamp_v = (val_i < MIN_V) ? MIN_V : (val_i > MAX_V) ? MAX_V : val_i;
    up_sum  = {1'b0, exp_q} + STEP_V;
    lit4    = CW'(lit_cnt_i) << 2;
    nxt_v   = exp_q;
    if (lit4 < TOT1)
      nxt_v = (up_sum > {1'b0, MAX_V}) ? MAX_V : up_sum[EXP_W-1:0];
    else if (lit4 > TOT3)
      nxt_v = ({1'b0, exp_q} < {1'b0, MIN_V} + STEP_V) ? MIN_V
            : exp_q - STEP_V[EXP_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              exp_q <= MIN_V;
    else if (load_i)          exp_q <= clamp_v;
    else if (adj_i && ae_en_i) exp_q <= nxt_v;
  end

  assign exp_o = exp_q;

  p_exp_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exp_o >= MIN_V) && (exp_o <= MAX_V));
endmodule

// File: rtl/memcam_readout.sv
module memcam_readout #(
  parameter int COL_W  = 8,
  parameter int ROW_W  = 7,
  parameter int GRAY_W = 2,
  parameter int CNT_W  = 17
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   rd_i,
  input  logic                   first_i,
  input  logic                   preset_i,
  input  logic [COL_W-1:0]       x_i,
  input  logic [ROW_W-1:0]       y_i,
  input  logic                   mem_rdata_i,
  input  logic [GRAY_W-1:0]      gray_rdata_i,
  output logic [ROW_W+COL_W-1:0] gray_waddr_o,
  output logic [GRAY_W-1:0]      gray_wdata_o,
  output logic                   gray_we_o,
  output logic                   pix_valid_o,
  output logic [COL_W-1:0]       pix_x_o,
  output logic [ROW_W-1:0]       pix_y_o,
  output logic                   pix_lit_o,
  output logic [GRAY_W-1:0]      pix_gray_o,
  output logic [CNT_W-1:0]       lit_cnt_o
);
  localparam logic [GRAY_W-1:0] LVL = {GRAY_W{1'b1}};

  logic              v1_q, first1_q;
  logic [COL_W-1:0]  x1_q;
  logic [ROW_W-1:0]  y1_q;
  logic              lit;
  logic [GRAY_W-1:0] old_g, new_g;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0; first1_q <= 1'b0; x1_q <= '0; y1_q <= '0;
    end else begin
      v1_q <= rd_i; first1_q <= first_i; x1_q <= x_i; y1_q <= y_i;
    end
  end

  always_comb begin
    lit   = v1_q & (mem_rdata_i ^ preset_i);
    old_g = first1_q ? '0 : gray_rdata_i;
    new_g = (old_g == LVL) ? old_g : old_g + GRAY_W'(lit);
  end

  assign gray_we_o    = v1_q;
  assign gray_waddr_o = {y1_q, x1_q};
  assign gray_wdata_o = new_g;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o <= 1'b0; pix_x_o <= '0; pix_y_o <= '0;
      pix_lit_o <= 1'b0; pix_gray_o <= '0; cnt_q <= '0;
    end else begin
      pix_valid_o <= v1_q;
      pix_x_o     <= x1_q;
      pix_y_o     <= y1_q;
      pix_lit_o   <= lit;
      pix_gray_o  <= new_g;
      if (clr_i)            cnt_q <= '0;
      else if (v1_q && lit) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lit_cnt_o = cnt_q;

  p_stream_lag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> $past(rd_i, 2));
endmodule

// File: rtl/memcam_top.sv
module memcam_top
  import memcam_pkg::*;
#(
  parameter int COL_W    = 8,
  parameter int ROW_W    = 7,
  parameter int GRAY_W   = 2,
  parameter int EXP_W    = 16,
  parameter int EXP_MIN  = 1,
  parameter int EXP_MAX  = 60000,
  parameter int EXP_STEP = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   preset_i,
  input  logic                   ae_en_i,
  input  logic                   exp_load_i,
  input  logic [EXP_W-1:0]       exp_i,
  input  logic                   map_we_i,
  input  logic                   map_row_i,
  input  logic [COL_W-1:0]       map_idx_i,
  input  logic [COL_W-1:0]       map_val_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [EXP_W-1:0]       exp_o,
  output logic [ROW_W+COL_W-1:0] mem_addr_o,
  output logic                   mem_wdata_o,
  output logic                   mem_we_o,
  output logic                   mem_re_o,
  input  logic                   mem_rdata_i,
  output logic [ROW_W+COL_W-1:0] gray_raddr_o,
  input  logic [GRAY_W-1:0]      gray_rdata_i,
  output logic [ROW_W+COL_W-1:0] gray_waddr_o,
  output logic [GRAY_W-1:0]      gray_wdata_o,
  output logic                   gray_we_o,
  output logic                   pix_valid_o,
  output logic [COL_W-1:0]       pix_x_o,
  output logic [ROW_W-1:0]       pix_y_o,
  output logic                   pix_lit_o,
  output logic [GRAY_W-1:0]      pix_gray_o
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int NPIX   = 1 << ADDR_W;
  localparam int LEVELS = (1 << GRAY_W) - 1;
  localparam int TOTAL  = LEVELS * NPIX;
  localparam int CNT_W  = $clog2(TOTAL + 1);
  localparam int TMR_W  = EXP_W + GRAY_W + 1;
  localparam logic [ADDR_W-1:0] LAST_A = {ADDR_W{1'b1}};
  localparam logic [GRAY_W-1:0] LAST_P = GRAY_W'(LEVELS - 1);

  cap_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [GRAY_W-1:0] pass_q;
  logic [TMR_W-1:0]  tmr_q, target;
  logic              preset_q, idle, accept;
  logic [COL_W-1:0]  map_x;
  logic [ROW_W-1:0]  map_y;
  logic [CNT_W-1:0]  lit_cnt;

  assign idle   = (state_q == ST_IDLE);
  assign accept = idle && start_i;
  assign target = TMR_W'(exp_o) * (TMR_W'(pass_q) + 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; addr_q <= '0; pass_q <= '0;
      tmr_q <= '0; preset_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_PRESET; addr_q <= '0; pass_q <= '0; preset_q <= preset_i;
        end
        ST_PRESET: begin
          addr_q <= addr_q + 1'b1;
          if (addr_q == LAST_A) begin
            state_q <= ST_EXPOSE;
            tmr_q   <= target - 1'b1;
          end
        end
        ST_EXPOSE: begin
          tmr_q <= tmr_q - 1'b1;
          if (tmr_q == '0) state_q <= ST_READ;
        end
        ST_READ: begin
          addr_q <= addr_q + 1'b1;
          if (addr_q == LAST_A) begin
            if (pass_q == LAST_P) state_q <= ST_FLUSH;
            else begin
              pass_q  <= pass_q + 1'b1;
              state_q <= ST_PRESET;
            end
          end
        end
        ST_FLUSH: state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = !idle;
  assign done_o       = (state_q == ST_DONE);
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = preset_q;
  assign mem_we_o     = (state_q == ST_PRESET);
  assign mem_re_o     = (state_q == ST_READ);
  assign gray_raddr_o = {map_y, map_x};

  memcam_remap #(.COL_W(COL_W), .ROW_W(ROW_W)) u_remap (
    .clk_i, .rst_ni,
    .we_i      (map_we_i && idle),
    .row_sel_i (map_row_i),
    .idx_i     (map_idx_i),
    .val_i     (map_val_i),
    .col_i     (addr_q[COL_W-1:0]),
    .row_i     (addr_q[ADDR_W-1:COL_W]),
    .x_o       (map_x),
    .y_o       (map_y)
  );

  memcam_expo #(
    .EXP_W(EXP_W), .EXP_MIN(EXP_MIN), .EXP_MAX(EXP_MAX),
    .EXP_STEP(EXP_STEP), .CNT_W(CNT_W), .TOTAL(TOTAL)
  ) u_expo (
    .clk_i, .rst_ni,
    .load_i    (exp_load_i && idle),
    .val_i     (exp_i),
    .adj_i     (done_o),
    .ae_en_i   (ae_en_i),
    .lit_cnt_i (lit_cnt),
    .exp_o     (exp_o)
  );

  memcam_readout #(
    .COL_W(COL_W), .ROW_W(ROW_W), .GRAY_W(GRAY_W), .CNT_W(CNT_W)
  ) u_rdout (
    .clk_i, .rst_ni,
    .clr_i        (accept),
    .rd_i         (mem_re_o),
    .first_i      (pass_q == '0),
    .preset_i     (preset_q),
    .x_i          (map_x),
    .y_i          (map_y),
    .mem_rdata_i,
    .gray_rdata_i,
    .gray_waddr_o,
    .gray_wdata_o,
    .gray_we_o,
    .pix_valid_o,
    .pix_x_o,
    .pix_y_o,
    .pix_lit_o,
    .pix_gray_o,
    .lit_cnt_o    (lit_cnt)
  );

  p_quiet_after_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(mem_we_o) && busy_o) |-> !mem_re_o);
  p_read_after_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_re_o) |-> !$past(mem_we_o));
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_start_only_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
  p_no_mixed_access_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
endmodule

// File: tb/sim_memcam_top.sv
module sim_memcam_top;
  localparam int COL_W = 2, ROW_W = 2, GRAY_W = 2, EXP_W = 8;
  localparam int EMIN = 2, EMAX = 20, ESTEP = 4;
  localparam int NPIX = 16, LEVELS = 3, TOTAL = 48;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 0, preset_i = 0, ae_en_i = 0, exp_load_i = 0;
  logic [EXP_W-1:0] exp_i = '0;
  logic map_we_i = 0, map_row_i = 0;
  logic [COL_W-1:0] map_idx_i = '0, map_val_i = '0;
  logic busy_o, done_o, mem_wdata_o, mem_we_o, mem_re_o, gray_we_o;
  logic [EXP_W-1:0] exp_o;
  logic [3:0] mem_addr_o, gray_raddr_o, gray_waddr_o;
  logic mem_rdata_i;
  logic [GRAY_W-1:0] gray_rdata_i, gray_wdata_o, pix_gray_o;
  logic pix_valid_o, pix_lit_o;
  logic [COL_W-1:0] pix_x_o;
  logic [ROW_W-1:0] pix_y_o;

  always #2.5 clk = ~clk;

  memcam_top #(.COL_W(COL_W), .ROW_W(ROW_W), .GRAY_W(GRAY_W), .EXP_W(EXP_W),
    .EXP_MIN(EMIN), .EXP_MAX(EMAX), .EXP_STEP(ESTEP)) u0 (
    .clk_i(clk), .rst_ni, .start_i, .preset_i, .ae_en_i, .exp_load_i, .exp_i,
    .map_we_i, .map_row_i, .map_idx_i, .map_val_i, .busy_o, .done_o, .exp_o,
    .mem_addr_o, .mem_wdata_o, .mem_we_o, .mem_re_o, .mem_rdata_i,
    .gray_raddr_o, .gray_rdata_i, .gray_waddr_o, .gray_wdata_o, .gray_we_o,
    .pix_valid_o, .pix_x_o, .pix_y_o, .pix_lit_o, .pix_gray_o);

  int checks = 0, errors = 0;
  int thr [NPIX];
  int cmap [4], rmap [4];
  logic smem [NPIX];
  logic [1:0] gstore [NPIX];
  int quiet = 0;
  logic cur_preset = 0;
  int wexp_addr = 0, run = 0;
  logic [6:0] sb_q [$];
  int len_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // sensor and frame-store models, one cycle read latency
  initial for (int i = 0; i < NPIX; i++) gstore[i] = 2'b11;
  always @(posedge clk) begin
    if (mem_we_o) begin
      smem[mem_addr_o] <= mem_wdata_o;
      quiet <= 0;
    end else if (mem_re_o) begin
      mem_rdata_i <= (quiet >= thr[mem_addr_o]) ? ~smem[mem_addr_o] : smem[mem_addr_o];
    end else begin
      quiet <= quiet + 1;
    end
    if (gray_we_o) gstore[gray_waddr_o] <= gray_wdata_o;
    gray_rdata_i <= gstore[gray_raddr_o];
  end

  // monitor: fill sweep, quiet window length, pixel stream scoreboard
  always @(negedge clk) if (rst_ni) begin
    if (mem_we_o) begin
      chk(mem_addr_o == 4'(wexp_addr) && mem_wdata_o == cur_preset,
          "R1 R11 fill addr/data", {mem_addr_o, mem_wdata_o}, {4'(wexp_addr), cur_preset});
      wexp_addr = (wexp_addr + 1) % NPIX;
      run = 0;
    end else if (mem_re_o) begin
      if (run > 0) begin
        if (len_q.size() == 0) chk(0, "R4 extra pass", run, 0);
        else begin
          int e;
          e = len_q.pop_front();
          chk(run == e, "R2 quiet cycles", run, e);
        end
      end
      run = 0;
    end else if (busy_o) begin
      run++;
    end
    if (pix_valid_o) begin
      logic [6:0] got;
      got = {pix_x_o, pix_y_o, pix_lit_o, pix_gray_o};
      if (sb_q.size() == 0) chk(0, "R7 unexpected beat", got, 0);
      else begin
        logic [6:0] e;
        e = sb_q.pop_front();
        chk(got == e, "R3 R5 R6 R7 pixel beat", got, e);
      end
    end
  end

  int exp_now = EMIN;

  task automatic load_exp(input int v);
    @(negedge clk); exp_load_i = 1; exp_i = EXP_W'(v);
    @(negedge clk); exp_load_i = 0;
    exp_now = (v < EMIN) ? EMIN : (v > EMAX) ? EMAX : v;
    chk(exp_o == EXP_W'(exp_now), "R10 exposure load", exp_o, exp_now);
  endtask

  task automatic map_write(input bit is_row, input int idx, input int val);
    @(negedge clk); map_we_i = 1; map_row_i = is_row;
    map_idx_i = COL_W'(idx); map_val_i = COL_W'(val);
    @(negedge clk); map_we_i = 0;
    if (is_row) rmap[idx] = val; else cmap[idx] = val;
  endtask

  task automatic run_frame(input logic pre, input logic ae, input bit poke);
    int g [NPIX];
    int lit_tot;
    lit_tot = 0;
    for (int k = 0; k < LEVELS; k++) begin
      int e;
      e = exp_now * (k + 1);
      len_q.push_back(e);
      for (int a = 0; a < NPIX; a++) begin
        int x, y, p;
        bit l;
        x = cmap[a % 4]; y = rmap[a / 4]; p = y * 4 + x;
        l = (thr[a] <= e);
        if (k == 0) g[p] = 0;
        if (l && g[p] < LEVELS) g[p]++;
        lit_tot += int'(l);
        sb_q.push_back({2'(x), 2'(y), l, 2'(g[p])});
      end
    end
    cur_preset = pre;
    wexp_addr = 0;
    @(negedge clk); preset_i = pre; ae_en_i = ae; start_i = 1;
    @(negedge clk); start_i = 0;
    chk(busy_o == 1, "R8 busy after start", busy_o, 1);
    if (poke) begin
      repeat (10) @(negedge clk);
      start_i = 1; preset_i = ~pre;
      @(negedge clk); start_i = 0;
    end
    while (!done_o) @(negedge clk);
    @(negedge clk);
    chk(done_o == 0 && busy_o == 0, "R8 done one cycle", {done_o, busy_o}, 0);
    if (ae) begin
      if (lit_tot * 4 < TOTAL) exp_now = (exp_now + ESTEP > EMAX) ? EMAX : exp_now + ESTEP;
      else if (lit_tot * 4 > 3 * TOTAL) exp_now = (exp_now < EMIN + ESTEP) ? EMIN : exp_now - ESTEP;
    end
    chk(exp_o == EXP_W'(exp_now), "R9 exposure after frame", exp_o, exp_now);
    chk(sb_q.size() == 0, "R7 beats missing", sb_q.size(), 0);
    chk(len_q.size() == 0, "R4 passes missing", len_q.size(), 0);
    repeat (3) @(negedge clk);
    chk(busy_o == 0, "R8 start while busy ignored", busy_o, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin cmap[i] = i; rmap[i] = i; end
    for (int i = 0; i < NPIX; i++) thr[i] = 200;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0, "R8 reset state", {busy_o, done_o}, 0);
    chk(exp_o == EXP_W'(EMIN), "R10 reset exposure", exp_o, EMIN);
    chk(mem_we_o == 0 && pix_valid_o == 0, "R1 reset outputs", {mem_we_o, pix_valid_o}, 0);

    load_exp(50);
    load_exp(1);
    load_exp(4);

    // staggered thresholds: pixels light in different passes or never
    for (int a = 0; a < NPIX; a++) thr[a] = (a * 3) % 14 + 1;
    run_frame(1'b0, 1'b0, 1'b0);
    // permuted tables, inverted fill, start pulse during the capture
    map_write(0, 0, 3); map_write(0, 1, 2); map_write(0, 2, 1); map_write(0, 3, 0);
    map_write(1, 0, 1); map_write(1, 1, 2); map_write(1, 2, 3); map_write(1, 3, 0);
    run_frame(1'b1, 1'b0, 1'b1);

    // auto-exposure: dark scene raises, clamps at max
    for (int a = 0; a < NPIX; a++) thr[a] = 200;
    run_frame(1'b0, 1'b1, 1'b0);
    load_exp(18);
    run_frame(1'b1, 1'b1, 1'b0);
    // bright scene lowers, clamps at min
    for (int a = 0; a < NPIX; a++) thr[a] = 1;
    run_frame(1'b0, 1'b1, 1'b0);
    load_exp(4);
    run_frame(1'b0, 1'b1, 1'b0);
    // half lit: no change
    load_exp(8);
    for (int a = 0; a < NPIX; a++) thr[a] = (a < 8) ? 1 : 200;
    run_frame(1'b0, 1'b1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule